// File: doc/BRIEF.md
# Pulse Transmitter Loop Controller

This block sequences one transmit channel of a pulse-train generator. It walks a symbol memory through an asynchronous read port: each 16-bit word pairs an output level with a duration in ticks. The controller drives that level for the given number of tick-enabled cycles and then moves to the next word. A word with zero duration ends the frame. The channel then either stops and reports completion, or in continuous mode rewinds to address zero and plays the frame again.

Commands and mode bits reach the channel only through an update strobe. Start and stop requests, and a new set of mode, count and limit values, are taken in the same cycle the strobe is high; at any other time they are ignored. A pass counter bounds repetition in continuous mode and raises its own event when it reaches the programmed count. A symbol-count threshold event marks progress within each pass. While idle, the output either sits at a programmed fixed level or keeps the level of the word that ended the last frame.

Top module: `ptx_loop_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, the channel is idle, `sym_raddr` is 0, `pulse_out` is 0 and all three event outputs are 0.
- R2: `cmd_start` starts playback only in a cycle where `cfg_update` is high. Without the strobe it has no effect, and the channel stays idle with its read address unchanged.
- R3: `cmd_stop` has no effect unless `cfg_update` is high in the same cycle. With the strobe, playback halts at that edge and `ev_done` is not raised. A stop takes priority over a start given in the same cycle.
- R4: A symbol word carries its level in bit 15 and its duration in bits 14:0. While running, `pulse_out` equals the level of the word at `sym_raddr`. The address advances by one after the duration's worth of tick-enabled cycles.
- R5: A word with duration 0 ends the frame. In one-shot mode the channel goes idle at the next edge and pulses `ev_done` for exactly one cycle.
- R6: When idle, `pulse_out` is the programmed fixed level if fixed-idle is enabled. Otherwise it is the level bit of the word that ended the last frame.
- R7: The mode bits, the pass count and the threshold are captured only in a cycle with `cfg_update` high. Changing them without the strobe changes nothing.
- R8: `ev_thresh` pulses for one cycle, in the cycle after the edge at which the number of words sent since the start, or since the last rewind, reaches `cfg_limit`. A limit of 0 never fires.
- R9: In continuous mode with the pass counter disabled, a frame end rewinds the address to 0 and playback continues without `ev_done`.
- R10: In continuous mode with the pass counter enabled, each frame end increments the counter. The frame end that brings it to `cfg_loop_num` (1 to 1023) stops the channel and pulses `ev_loop_end` instead of `ev_done`.
- R11: The pass counter keeps its value between runs. Only a `loop_cnt_clr` pulse returns it to zero.
- R12: `rdptr_rst` returns `sym_raddr` to 0 at the next edge, whether the channel is idle or running.
- R13: With `tick_en` low, the duration count of the current word does not advance and the address holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | One duration tick per cycle when high |
| cfg_update | input | 1 | Strobe that applies commands and mode values |
| cmd_start | input | 1 | Start request (needs the strobe) |
| cmd_stop | input | 1 | Stop request (needs the strobe) |
| rdptr_rst | input | 1 | Return the read address to 0 |
| loop_cnt_clr | input | 1 | Clear the pass counter |
| cfg_continuous | input | 1 | Replay the frame repeatedly |
| cfg_loop_en | input | 1 | Enable the pass counter |
| cfg_loop_num | input | LOOP_W (10) | Pass count that ends continuous playback; 0 = unbounded |
| cfg_limit | input | LIM_W (7) | Words per pass before the threshold event; 0 = off |
| cfg_idle_fix | input | 1 | Drive a fixed level when idle |
| cfg_idle_lvl | input | 1 | The fixed idle level |
| sym_rdata | input | 16 | Symbol word at `sym_raddr` (same-cycle read) |
| sym_raddr | output | ADDR_W (6) | Symbol read address |
| pulse_out | output | 1 | Unmodulated output level |
| ev_done | output | 1 | One-cycle pulse at the end of a one-shot frame |
| ev_thresh | output | 1 | One-cycle pulse when the word threshold is reached |
| ev_loop_end | output | 1 | One-cycle pulse when the pass count is reached |

## Verification
The read address and `pulse_out` follow a command in the cycle after the edge that samples it. The output is the memory word's level, so running from that edge it shows word 0. Every event is registered. `ev_thresh` is seen in the cycle after the edge at which the threshold word is left, so at offset S_L from the start edge, where S_L sums the first L durations. `ev_done` is seen at offset sum+1, because the end word takes one cycle of its own. In continuous mode each pass lasts sum+1 cycles, so the pass-count event is due at N·(sum+1). The bench drives and samples 2 ns after each rising edge, numbers every sample by its offset from the start edge, and compares each output only at the offset derived here.

// File: rtl/ptx_pkg.sv
package ptx_pkg;
    localparam int DUR_W = 15;
    localparam int SYM_W = DUR_W + 1;

    typedef struct packed {
        logic             lvl;
        logic [DUR_W-1:0] dur;
    } sym_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } st_e;

    typedef struct packed {
        logic cont;
        logic loop_en;
        logic idle_fix;
        logic idle_lvl;
    } mode_t;
endpackage

// File: rtl/ptx_cfg_shadow.sv
module ptx_cfg_shadow
    import ptx_pkg::*;
#(
    parameter int LOOP_W = 10,
    parameter int LIM_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd,
    input  mode_t             mode_in,
    input  logic [LOOP_W-1:0] num_in,
    input  logic [LIM_W-1:0]  lim_in,
    output mode_t             mode_q,
    output logic [LOOP_W-1:0] num_q,
    output logic [LIM_W-1:0]  lim_q
);
    typedef struct packed {
        mode_t             mode;
        logic [LOOP_W-1:0] num;
        logic [LIM_W-1:0]  lim;
    } shadow_t;

    shadow_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (upd) begin
            sh_d.mode = mode_in;
            sh_d.num  = num_in;
            sh_d.lim  = lim_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign mode_q = sh_q.mode;
    assign num_q  = sh_q.num;
    assign lim_q  = sh_q.lim;

    // R7: settings move only with the strobe
    assert_hold_without_update_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(sh_q));
endmodule

// File: rtl/ptx_loop_cnt.sv
module ptx_loop_cnt #(
    parameter int LOOP_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              inc,
    input  logic [LOOP_W-1:0] num,
    output logic              term
);
    logic [LOOP_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)      cnt_d = '0;
        else if (inc) cnt_d = cnt_q + LOOP_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign term = inc && !clr && (num != '0) && ((cnt_q + LOOP_W'(1)) == num);

    // R11: a clear pulse empties the counter
    assert_clear_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));
    // R10: count 0 never terminates
    assert_zero_never_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (num == '0) |-> !term);
endmodule

// File: rtl/ptx_seq_fsm.sv
module ptx_seq_fsm
    import ptx_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LIM_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              upd,
    input  logic              start,
    input  logic              stop,
    input  logic              rdptr_rst,
    input  sym_t              sym,
    input  mode_t             mode,
    input  logic [LIM_W-1:0]  lim,
    input  logic              loop_term,
    output logic              pass_end,
    output logic [ADDR_W-1:0] addr,
    output logic              out_lvl,
    output logic              ev_done,
    output logic              ev_thr,
    output logic              ev_end
);
    typedef struct packed {
        st_e              st;
        logic [ADDR_W-1:0] addr;
        logic [DUR_W-1:0]  cnt;
        logic [LIM_W-1:0]  sent;
        logic              eof_lvl;
        logic              ev_done;
        logic              ev_thr;
        logic              ev_end;
    } seq_t;

    seq_t s_d, s_q;
    logic kill;
    logic is_eof;

    assign kill   = upd && stop;
    assign is_eof = (sym.dur == '0);

    always_comb begin
        s_d         = s_q;
        s_d.ev_done = 1'b0;
        s_d.ev_thr  = 1'b0;
        s_d.ev_end  = 1'b0;
        pass_end    = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (upd && start && !stop) begin
                    s_d.st   = ST_RUN;
                    s_d.cnt  = '0;
                    s_d.sent = '0;
                end
            end
            ST_RUN: begin
                if (kill) begin
                    s_d.st = ST_IDLE;
                end else if (is_eof) begin
                    if (mode.cont) begin
                        pass_end = mode.loop_en;
                        if (mode.loop_en && loop_term) begin
                            s_d.st      = ST_IDLE;
                            s_d.eof_lvl = sym.lvl;
                            s_d.ev_end  = 1'b1;
                        end else begin
                            s_d.addr = '0;
                            s_d.cnt  = '0;
                            s_d.sent = '0;
                        end
                    end else begin
                        s_d.st      = ST_IDLE;
                        s_d.eof_lvl = sym.lvl;
                        s_d.ev_done = 1'b1;
                    end
                end else if (tick_en) begin
                    if ((s_q.cnt + DUR_W'(1)) == sym.dur) begin
                        s_d.addr = s_q.addr + ADDR_W'(1);
                        s_d.cnt  = '0;
                        if (s_q.sent != '1) s_d.sent = s_q.sent + LIM_W'(1);
                        if ((lim != '0) && ((s_q.sent + LIM_W'(1)) == lim))
                            s_d.ev_thr = 1'b1;
                    end else begin
                        s_d.cnt = s_q.cnt + DUR_W'(1);
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
        if (rdptr_rst) begin
            s_d.addr = '0;
            s_d.cnt  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign addr    = s_q.addr;
    assign out_lvl = (s_q.st == ST_RUN) ? sym.lvl
                   : (mode.idle_fix ? mode.idle_lvl : s_q.eof_lvl);
    assign ev_done = s_q.ev_done;
    assign ev_thr  = s_q.ev_thr;
    assign ev_end  = s_q.ev_end;

    // R2: no strobe, no start
    assert_idle_without_update_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_IDLE && !upd) |=> (s_q.st == ST_IDLE));
    // R3: strobed stop halts without completion
    assert_stop_halts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_RUN && kill) |=> (s_q.st == ST_IDLE && !s_q.ev_done));
    // R5: completion is a single-cycle pulse out of a run
    assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.ev_done |=> !s_q.ev_done);
    assert_done_after_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.ev_done |-> $past(s_q.st == ST_RUN));
    // R10: pass-count end and completion never coincide
    assert_events_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({s_q.ev_done, s_q.ev_end}));
    // R12: pointer reset
    assert_pointer_reset_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rdptr_rst |=> (s_q.addr == '0));
    // R13: no tick, no advance
    assert_tick_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_RUN && !tick_en && !is_eof && !rdptr_rst && !kill) |=> $stable(s_q.addr));
endmodule

// File: rtl/ptx_loop_ctrl.sv
module ptx_loop_ctrl
    import ptx_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LOOP_W = 10,
    parameter int LIM_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              cfg_update,
    input  logic              cmd_start,
    input  logic              cmd_stop,
    input  logic              rdptr_rst,
    input  logic              loop_cnt_clr,
    input  logic              cfg_continuous,
    input  logic              cfg_loop_en,
    input  logic [LOOP_W-1:0] cfg_loop_num,
    input  logic [LIM_W-1:0]  cfg_limit,
    input  logic              cfg_idle_fix,
    input  logic              cfg_idle_lvl,
    input  logic [SYM_W-1:0]  sym_rdata,
    output logic [ADDR_W-1:0] sym_raddr,
    output logic              pulse_out,
    output logic              ev_done,
    output logic              ev_thresh,
    output logic              ev_loop_end
);
    mode_t             mode_in, mode_q;
    logic [LOOP_W-1:0] num_q;
    logic [LIM_W-1:0]  lim_q;
    logic              pass_end;
    logic              loop_term;
    sym_t              sym_w;

    assign mode_in = '{cont: cfg_continuous, loop_en: cfg_loop_en,
                       idle_fix: cfg_idle_fix, idle_lvl: cfg_idle_lvl};
    assign sym_w   = sym_t'(sym_rdata);

    ptx_cfg_shadow #(.LOOP_W(LOOP_W), .LIM_W(LIM_W)) u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd     (cfg_update),
        .mode_in (mode_in),
        .num_in  (cfg_loop_num),
        .lim_in  (cfg_limit),
        .mode_q  (mode_q),
        .num_q   (num_q),
        .lim_q   (lim_q)
    );

    ptx_loop_cnt #(.LOOP_W(LOOP_W)) u_loops (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (loop_cnt_clr),
        .inc   (pass_end),
        .num   (num_q),
        .term  (loop_term)
    );

    ptx_seq_fsm #(.ADDR_W(ADDR_W), .LIM_W(LIM_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .upd       (cfg_update),
        .start     (cmd_start),
        .stop      (cmd_stop),
        .rdptr_rst (rdptr_rst),
        .sym       (sym_w),
        .mode      (mode_q),
        .lim       (lim_q),
        .loop_term (loop_term),
        .pass_end  (pass_end),
        .addr      (sym_raddr),
        .out_lvl   (pulse_out),
        .ev_done   (ev_done),
        .ev_thr    (ev_thresh),
        .ev_end    (ev_loop_end)
    );
endmodule

// File: tb/ptx_loop_ctrl_bench.sv
module ptx_loop_ctrl_bench;
    localparam int ADDR_W = 6;
    localparam int LOOP_W = 10;
    localparam int LIM_W  = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_en = 1'b1, cfg_update = 1'b0, cmd_start = 1'b0, cmd_stop = 1'b0;
    logic rdptr_rst = 1'b0, loop_cnt_clr = 1'b0;
    logic cfg_continuous = 1'b0, cfg_loop_en = 1'b0, cfg_idle_fix = 1'b0, cfg_idle_lvl = 1'b0;
    logic [LOOP_W-1:0] cfg_loop_num = '0;
    logic [LIM_W-1:0]  cfg_limit = '0;
    logic [15:0]       sym_rdata;
    logic [ADDR_W-1:0] sym_raddr;
    logic pulse_out, ev_done, ev_thresh, ev_loop_end;

    logic [15:0] mem [64];
    assign sym_rdata = mem[sym_raddr];

    always #10 clk = ~clk;

    ptx_loop_ctrl #(.ADDR_W(ADDR_W), .LOOP_W(LOOP_W), .LIM_W(LIM_W)) u_ptx_loop_ctrl (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cfg_update(cfg_update),
        .cmd_start(cmd_start), .cmd_stop(cmd_stop), .rdptr_rst(rdptr_rst),
        .loop_cnt_clr(loop_cnt_clr), .cfg_continuous(cfg_continuous),
        .cfg_loop_en(cfg_loop_en), .cfg_loop_num(cfg_loop_num), .cfg_limit(cfg_limit),
        .cfg_idle_fix(cfg_idle_fix), .cfg_idle_lvl(cfg_idle_lvl),
        .sym_rdata(sym_rdata), .sym_raddr(sym_raddr), .pulse_out(pulse_out),
        .ev_done(ev_done), .ev_thresh(ev_thresh), .ev_loop_end(ev_loop_end)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // three timed words then an end word; lv = {l0,l1,l2,end level}
    typedef struct packed {
        logic [7:0] d0;
        logic [7:0] d1;
        logic [7:0] d2;
        logic [3:0] lv;
        logic [6:0] lim;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{8'd3, 8'd1, 8'd5, 4'b1010, 7'd2},
        '{8'd1, 8'd1, 8'd1, 4'b0101, 7'd3},
        '{8'd4, 8'd2, 8'd2, 4'b1101, 7'd0},
        '{8'd2, 8'd6, 8'd1, 4'b0110, 7'd1}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    function automatic logic [15:0] word(input logic l, input int d);
        return {l, 15'(d)};
    endfunction

    task automatic launch(input logic cont, input logic len, input int num,
                          input int lim, input logic clr);
        rdptr_rst = 1'b1; cfg_update = 1'b1; cmd_start = 1'b1;
        cfg_continuous = cont; cfg_loop_en = len;
        cfg_loop_num = LOOP_W'(num); cfg_limit = LIM_W'(lim);
        loop_cnt_clr = clr;
        cyc();
        rdptr_rst = 1'b0; cfg_update = 1'b0; cmd_start = 1'b0; loop_cnt_clr = 1'b0;
    endtask

    task automatic halt();
        cmd_stop = 1'b1; cfg_update = 1'b1;
        cyc();
        cmd_stop = 1'b0; cfg_update = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = '0;
        repeat (3) cyc();
        // R1: state during reset
        chk(sym_raddr == 0 && pulse_out == 0 && !ev_done && !ev_thresh && !ev_loop_end,
            "R1 in reset", {sym_raddr, pulse_out}, 0);
        rst_n = 1'b1;
        cyc();
        chk(sym_raddr == 0 && pulse_out == 0 && !ev_done && !ev_thresh && !ev_loop_end,
            "R1 after reset", {sym_raddr, pulse_out}, 0);

        // table of one-shot frames
        for (int v = 0; v < 4; v++) begin
            int d [3];
            logic l [3];
            int sum, s_lim, lvl_bad, thr_bad, done_bad;
            d[0] = int'(VECS[v].d0); d[1] = int'(VECS[v].d1); d[2] = int'(VECS[v].d2);
            l[0] = VECS[v].lv[3]; l[1] = VECS[v].lv[2]; l[2] = VECS[v].lv[1];
            sum = d[0] + d[1] + d[2];
            s_lim = 0;
            for (int k = 0; k < int'(VECS[v].lim); k++) s_lim += d[k];
            for (int k = 0; k < 3; k++) mem[k] = word(l[k], d[k]);
            mem[3] = word(VECS[v].lv[0], 0);
            lvl_bad = 0; thr_bad = 0; done_bad = 0;
            launch(1'b0, 1'b0, 0, int'(VECS[v].lim), 1'b0);
            for (int j = 0; j <= sum + 1; j++) begin
                logic e;
                if (j > 0) cyc();
                if (j < d[0]) e = l[0];
                else if (j < d[0] + d[1]) e = l[1];
                else if (j < sum) e = l[2];
                else e = VECS[v].lv[0];
                if (pulse_out !== e) lvl_bad++;
                if (ev_thresh !== (VECS[v].lim != 0 && j == s_lim)) thr_bad++;
                if (ev_done !== (j == sum + 1)) done_bad++;
            end
            chk(lvl_bad == 0, "R4 level sequence", lvl_bad, 0);
            chk(thr_bad == 0, "R8 threshold timing", thr_bad, 0);
            chk(done_bad == 0, "R5 done timing", done_bad, 0);
            chk(sym_raddr == 3, "R4 address at frame end", sym_raddr, 3);
            cyc();
            chk(pulse_out == VECS[v].lv[0] && !ev_done, "R6 idle holds end level",
                pulse_out, VECS[v].lv[0]);
        end

        // R7 / R6: fixed idle only after the strobe (last end level was 0)
        cfg_idle_fix = 1'b1; cfg_idle_lvl = 1'b1;
        cyc(); cyc();
        chk(pulse_out == 1'b0, "R7 no strobe no change", pulse_out, 0);
        cfg_update = 1'b1;
        cyc();
        cfg_update = 1'b0;
        chk(pulse_out == 1'b1, "R6 fixed idle level", pulse_out, 1);
        cfg_idle_fix = 1'b0; cfg_update = 1'b1;
        cyc();
        cfg_update = 1'b0;
        chk(pulse_out == 1'b0, "R6 fixed idle released", pulse_out, 0);

        // R2: start without strobe
        mem[0] = word(1'b1, 50); mem[1] = word(1'b0, 0);
        rdptr_rst = 1'b1; cmd_start = 1'b1;
        cyc();
        rdptr_rst = 1'b0;
        repeat (4) cyc();
        cmd_start = 1'b0;
        chk(pulse_out == 1'b0 && sym_raddr == 0, "R2 start ignored without strobe", pulse_out, 0);

        // R13: no ticks, no progress
        tick_en = 1'b0;
        launch(1'b0, 1'b0, 0, 0, 1'b0);
        repeat (60) cyc();
        chk(pulse_out == 1'b1 && sym_raddr == 0, "R13 frozen without ticks", sym_raddr, 0);
        tick_en = 1'b1;

        // R3: stop needs the strobe
        cmd_stop = 1'b1;
        repeat (3) cyc();
        cmd_stop = 1'b0;
        chk(pulse_out == 1'b1, "R3 stop ignored without strobe", pulse_out, 1);
        halt();
        chk(pulse_out == 1'b0 && !ev_done, "R3 strobed stop halts", pulse_out, 0);
        cyc();
        chk(!ev_done && pulse_out == 1'b0, "R3 no done after stop", ev_done, 0);

        // R12: pointer reset while running
        mem[0] = word(1'b0, 2); mem[1] = word(1'b1, 2); mem[2] = word(1'b0, 40);
        mem[3] = word(1'b0, 0);
        launch(1'b0, 1'b0, 0, 0, 1'b0);
        repeat (5) cyc();
        chk(sym_raddr == 2, "R4 address after two words", sym_raddr, 2);
        rdptr_rst = 1'b1;
        cyc();
        rdptr_rst = 1'b0;
        chk(sym_raddr == 0, "R12 pointer reset while running", sym_raddr, 0);
        halt();

        // R9: continuous replay without pass counter
        mem[0] = word(1'b1, 2); mem[1] = word(1'b0, 3); mem[2] = word(1'b1, 0);
        begin
            int done_seen = 0;
            logic [ADDR_W-1:0] a5 = '1, a6 = '1;
            logic o6 = 1'b0;
            launch(1'b1, 1'b0, 0, 0, 1'b0);
            for (int j = 1; j <= 20; j++) begin
                cyc();
                if (ev_done) done_seen++;
                if (j == 5) a5 = sym_raddr;
                if (j == 6) begin a6 = sym_raddr; o6 = pulse_out; end
            end
            chk(a5 == 2, "R9 end word reached", a5, 2);
            chk(a6 == 0 && o6 == 1'b1, "R9 rewound to start", a6, 0);
            chk(done_seen == 0, "R9 no done in continuous", done_seen, 0);
            halt();
        end

        // R10: three passes then stop with pass-end event
        begin
            int end_j = -1, ends = 0, dones = 0;
            launch(1'b1, 1'b1, 3, 0, 1'b1);
            for (int j = 1; j <= 25; j++) begin
                cyc();
                if (ev_loop_end) begin ends++; if (end_j < 0) end_j = j; end
                if (ev_done) dones++;
            end
            chk(end_j == 18 && ends == 1, "R10 pass count end", end_j, 18);
            chk(dones == 0, "R10 no done at pass end", dones, 0);
            chk(pulse_out == 1'b1, "R6 idle after pass end holds end level", pulse_out, 1);
        end

        // R11: counter persists (3 held, target 4 reached after one pass)
        begin
            int end_j = -1;
            launch(1'b1, 1'b1, 4, 0, 1'b0);
            for (int j = 1; j <= 10; j++) begin
                cyc();
                if (ev_loop_end && end_j < 0) end_j = j;
            end
            chk(end_j == 6, "R11 count kept between runs", end_j, 6);
        end
        // R11: clear then a one-pass target
        begin
            int end_j = -1;
            launch(1'b1, 1'b1, 1, 0, 1'b1);
            for (int j = 1; j <= 10; j++) begin
                cyc();
                if (ev_loop_end && end_j < 0) end_j = j;
            end
            chk(end_j == 6, "R11 clear restarts count", end_j, 6);
        end

        // R8: threshold fires once per pass in continuous mode (limit 1 -> j=2, 8)
        begin
            int hits = 0, bad = 0;
            launch(1'b1, 1'b0, 0, 1, 1'b0);
            for (int j = 1; j <= 11; j++) begin
                cyc();
                if (ev_thresh) begin hits++; if (j != 2 && j != 8) bad++; end
            end
            chk(hits == 2 && bad == 0, "R8 threshold per pass", hits, 2);
            halt();
        end

        // R3: stop wins over start in the same cycle
        cmd_start = 1'b1; cmd_stop = 1'b1; cfg_update = 1'b1; rdptr_rst = 1'b1;
        cfg_continuous = 1'b0;
        cyc();
        cmd_start = 1'b0; cmd_stop = 1'b0; cfg_update = 1'b0; rdptr_rst = 1'b0;
        repeat (3) cyc();
        chk(sym_raddr == 0 && pulse_out == 1'b1, "R3 stop beats start", sym_raddr, 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule